// File: doc/BRIEF.md
# Bus Width Translation Cycle Controller

This block sits on the host side of a 16-bit expansion bus and turns single CPU memory or I/O requests into bus cycles. Every cycle starts with one status state, in which the address latch enable pulses and the address and high-byte enable are put on the bus. One or more command states follow, in which exactly one of four active-low strobes (memory read, memory write, I/O read, I/O write) is held low. A byte-wide or 16-bit default count of command states fixes the nominal length. The addressed target can stretch the cycle by pulling its ready line low, and a memory target can cut the cycle short with an active-low no-wait-state line.

A 16-bit request is first run as a 16-bit cycle. At the end of its first command state the controller samples the target's width claim: the memory claim line for memory cycles, the I/O claim line for I/O cycles. If the claim is absent, the controller finishes that cycle as an 8-bit cycle on the low lane and then runs a second 8-bit cycle at the next odd address. It moves the upper byte of the write data down to the low lane, or it picks up the upper byte of the read result from the low lane. The requester sees one `done` pulse with the assembled read data, after the last sub-cycle.

The requester offers a request for one cycle while `busy` is low. All timing is counted in bus-clock cycles. There is one state per clock.

Top module: `bus_xlate_ctrl`

## Requirements
- R1: After reset the address latch enable is low, all four command strobes and the high-byte enable are high, the data output enable is low, and `busy` and `done` are low.
- R2: A request accepted while `busy` is low starts a status state on the next cycle. In that state the address latch enable is high for exactly one cycle, the cycle's address is driven, and no command strobe is low. The first command state follows it directly.
- R3: In every command state exactly one strobe is low: memory read when `req_io`=0 and `req_write`=0, memory write when `req_io`=0 and `req_write`=1, I/O read when `req_io`=1 and `req_write`=0, I/O write when `req_io`=1 and `req_write`=1.
- R4: With the ready line high and the no-wait-state line high, a 16-bit cycle lasts CMD16_STATES command states (default 2). A byte cycle or a split sub-cycle lasts CMD8_STATES command states (default 4).
- R5: Each command state that ends with the ready line low is followed by one more command state, with the same strobe and the same address.
- R6: On a memory cycle, the no-wait-state line low at the end of a command state in which the ready line is high ends the cycle there. It has no effect on I/O cycles. When the ready line is low, the no-wait-state line has no effect.
- R7: A 16-bit request (`req_wide`=1) is sampled for its width claim only at the end of its first command state. Memory cycles use `tgt_mem16_n` and I/O cycles use `tgt_io16_n`, both active low. When the claim is present, one cycle runs at the even address (bit 0 forced to 0) with `bus_hbe_n` low and all 16 data bits on the bus.
- R8: A 16-bit request without a claim becomes two 8-bit cycles. The first runs at the even address with `bus_hbe_n` low and the low byte on D[7:0]. The second runs at the address with bit 0 set, with `bus_hbe_n` high, and moves the upper byte on D[7:0]. The read result is {second D[7:0], first D[7:0]}.
- R9: A byte request (`req_wide`=0) runs one 8-bit cycle at the given address with `bus_hbe_n` high and data on D[7:0]. The read result is zero-extended to 16 bits.
- R10: `done` is high for one cycle, the cycle after the final command state, with `busy` low and `rd_data` valid for reads. `busy` is high from the status state to the final command state. A request offered while `busy` is high is ignored.
- R11: `bus_doe` is high during the status and command states of write cycles, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte request |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | 16 | Write data (byte requests use bits 7:0) |
| busy | output | 1 | A bus cycle sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled read data, valid with `done` |
| bus_ale | output | 1 | Address latch enable, high in status states |
| bus_addr | output | AW | Bus address of the current cycle |
| bus_hbe_n | output | 1 | Active-low upper-byte-lane enable |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_dout | output | 16 | Write data toward the bus |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 16 | Read data from the bus |
| tgt_ready | input | 1 | Target ready; low inserts a wait state |
| tgt_nows_n | input | 1 | Memory target ends cycle early, active low |
| tgt_mem16_n | input | 1 | Memory target claims 16-bit width, active low |
| tgt_io16_n | input | 1 | I/O target claims 16-bit width, active low |

## Verification
The assertions take for granted that the target holds the ready line high whenever no command strobe is low. They also take for granted that the requester offers 16-bit requests only at even addresses, so the high-byte enable pairs only with an even address. The bench keeps to both rules. It changes the target lines only in command states and releases them at the end of every cycle. Its stimulus pokes a second request in the middle of a cycle, to show that such a request is dropped rather than letting it reach the bus.

// File: rtl/bxc_pkg.sv
// Shared types for the bus width translation cycle controller.
package bxc_pkg;

    // Bus phase of the sequencer: idle, status state, command state.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STAT = 2'd1,
        PH_CMD  = 2'd2
    } phase_t;

    // Kind of the latched request.
    typedef struct packed {
        logic wr;    // 1 = write
        logic io;    // 1 = I/O space
        logic wide;  // 1 = 16-bit request
    } kind_t;

    // What the read path captures when a command phase ends.
    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_FULL = 2'd1,
        CAP_LO   = 2'd2,
        CAP_HI   = 2'd3
    } cap_t;

endpackage

// File: rtl/bxc_term.sv
// Command-phase length counter and end-of-cycle decision.
// Counts the command states of the current cycle and decides, at each
// command state, whether the cycle ends at the coming clock edge.
// Assumes: ready low always holds the cycle, whatever else is asserted;
// early termination is honoured on memory cycles only.
module bxc_term #(
    parameter int C16 = 2,
    parameter int C8  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_cmd,
    input  logic eff16,
    input  logic mem_cycle,
    input  logic ready,
    input  logic nows_n,
    output logic first_cmd,
    output logic term_now
);
    localparam int MAXC = (C8 > C16) ? C8 : C16;
    localparam int CW   = $clog2(MAXC + 1) + 1;
    localparam logic [CW-1:0] LIM16 = CW'(C16);
    localparam logic [CW-1:0] LIM8  = CW'(C8);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [CW:0]   nxt;
    logic          reached;
    logic          early;

    // Limit for this cycle and the early-end request.
    always_comb begin
        lim       = eff16 ? LIM16 : LIM8;
        nxt       = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
        reached   = nxt >= {1'b0, lim};
        early     = mem_cycle & ~nows_n;
        first_cmd = in_cmd & (cnt == '0);
        term_now  = in_cmd & ready & (early | reached);
    end

    // Saturating count of command states completed in this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!in_cmd || term_now) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bxc_seq.sv
// Bus cycle sequencer: accepts a request, steps status and command
// states, samples the width claim once and schedules the second 8-bit
// sub-cycle when a 16-bit request is not claimed.
// Assumes: 16-bit requests carry an even address (bit 0 is replaced).
module bxc_seq
    import bxc_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  kind_t         req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic          mem16_n,
    input  logic          io16_n,
    input  logic          term_now,
    input  logic          first_cmd,
    output phase_t        phase,
    output kind_t         kind,
    output logic          split_hi,
    output logic          eff16,
    output logic [AW-1:0] cur_addr,
    output logic          busy,
    output logic          done,
    output logic          load,
    output cap_t          cap_mode
);
    logic [AW-1:0] addr_q;
    logic          claim_q;
    logic          width_now;
    logic          need_split;

    // Width claim, effective size, address and capture selection.
    always_comb begin
        width_now  = kind.io ? ~io16_n : ~mem16_n;
        eff16      = kind.wide & ~split_hi & (first_cmd ? width_now : claim_q);
        need_split = kind.wide & ~split_hi & ~eff16;
        cur_addr   = kind.wide ? {addr_q[AW-1:1], split_hi} : addr_q;
        busy       = (phase != PH_IDLE);
        load       = (phase == PH_IDLE) & req_valid;
        cap_mode   = CAP_NONE;
        if (phase == PH_CMD && term_now) begin
            if (eff16)         cap_mode = CAP_FULL;
            else if (split_hi) cap_mode = CAP_HI;
            else               cap_mode = CAP_LO;
        end
    end

    // Phase register, latched request and sub-cycle bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            kind     <= '0;
            addr_q   <= '0;
            split_hi <= 1'b0;
            claim_q  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        kind     <= req_kind;
                        addr_q   <= req_addr;
                        split_hi <= 1'b0;
                        claim_q  <= 1'b0;
                        phase    <= PH_STAT;
                    end
                end
                PH_STAT: begin
                    phase <= PH_CMD;
                end
                PH_CMD: begin
                    if (first_cmd) begin
                        claim_q <= kind.wide & width_now;
                    end
                    if (term_now) begin
                        if (need_split) begin
                            split_hi <= 1'b1;
                            phase    <= PH_STAT;
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bxc_lanes.sv
// Byte-lane steering: holds the write data, routes the proper byte onto
// each lane, and assembles read data from one or two captures.
// Assumes: 8-bit cycles always use the low lane.
module bxc_lanes
    import bxc_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LANES*8-1:0] wdata_in,
    input  logic               split_hi,
    input  cap_t               cap_mode,
    input  logic [LANES*8-1:0] bus_din,
    output logic [LANES*8-1:0] lane_out,
    output logic [LANES*8-1:0] rd_data
);
    localparam int DW = LANES * 8;

    logic [DW-1:0] wq;

    // Hold the write data of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)    wq <= '0;
        else if (load) wq <= wdata_in;
    end

    // Lane 0 carries the upper byte in the second sub-cycle; others pass.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign lane_out[7:0] = split_hi ? wq[DW-1:DW-8] : wq[7:0];
        end else begin : g_up
            assign lane_out[g*8 +: 8] = wq[g*8 +: 8];
        end
    end

    // Capture read data at the end of each command phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (cap_mode)
                CAP_FULL: rd_data <= bus_din;
                CAP_LO:   rd_data <= {{(DW-8){1'b0}}, bus_din[7:0]};
                CAP_HI:   rd_data[DW-1:DW-8] <= bus_din[7:0];
                default:  rd_data <= rd_data;
            endcase
        end
    end

endmodule

// File: rtl/bus_xlate_ctrl.sv
// Host-side cycle controller for a 16-bit expansion bus.
// Runs status and command states per request, honours wait states and
// early termination, and splits unclaimed 16-bit requests in two.
// Assumes: one request at a time, offered while busy is low.
module bus_xlate_ctrl
    import bxc_pkg::*;
#(
    parameter int AW           = 24,
    parameter int CMD16_STATES = 2,
    parameter int CMD8_STATES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_io,
    input  logic          req_wide,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic          busy,
    output logic          done,
    output logic [15:0]   rd_data,
    output logic          bus_ale,
    output logic [AW-1:0] bus_addr,
    output logic          bus_hbe_n,
    output logic          bus_memr_n,
    output logic          bus_memw_n,
    output logic          bus_ior_n,
    output logic          bus_iow_n,
    output logic [15:0]   bus_dout,
    output logic          bus_doe,
    input  logic [15:0]   bus_din,
    input  logic          tgt_ready,
    input  logic          tgt_nows_n,
    input  logic          tgt_mem16_n,
    input  logic          tgt_io16_n
);
    localparam int DW    = 16;
    localparam int LANES = DW / 8;

    phase_t phase;
    kind_t  kind;
    kind_t  req_kind;
    cap_t   cap_mode;
    logic   split_hi;
    logic   eff16;
    logic   first_cmd;
    logic   term_now;
    logic   load;
    logic   in_cmd;
    logic   active;

    // Pack the request fields.
    always_comb begin
        req_kind.wr   = req_write;
        req_kind.io   = req_io;
        req_kind.wide = req_wide;
    end

    bxc_seq #(.AW(AW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .mem16_n   (tgt_mem16_n),
        .io16_n    (tgt_io16_n),
        .term_now  (term_now),
        .first_cmd (first_cmd),
        .phase     (phase),
        .kind      (kind),
        .split_hi  (split_hi),
        .eff16     (eff16),
        .cur_addr  (bus_addr),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .cap_mode  (cap_mode)
    );

    bxc_term #(.C16(CMD16_STATES), .C8(CMD8_STATES)) i_term (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_cmd    (in_cmd),
        .eff16     (eff16),
        .mem_cycle (~kind.io),
        .ready     (tgt_ready),
        .nows_n    (tgt_nows_n),
        .first_cmd (first_cmd),
        .term_now  (term_now)
    );

    bxc_lanes #(.LANES(LANES)) i_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .wdata_in (req_wdata),
        .split_hi (split_hi),
        .cap_mode (cap_mode),
        .bus_din  (bus_din),
        .lane_out (bus_dout),
        .rd_data  (rd_data)
    );

    // Strobe, latch enable, lane enable and drive enable decode.
    always_comb begin
        in_cmd     = (phase == PH_CMD);
        active     = (phase == PH_STAT) | in_cmd;
        bus_ale    = (phase == PH_STAT);
        bus_memr_n = ~(in_cmd & ~kind.io & ~kind.wr);
        bus_memw_n = ~(in_cmd & ~kind.io &  kind.wr);
        bus_ior_n  = ~(in_cmd &  kind.io & ~kind.wr);
        bus_iow_n  = ~(in_cmd &  kind.io &  kind.wr);
        bus_hbe_n  = ~(active & kind.wide & ~split_hi);
        bus_doe    = active & kind.wr;
    end

endmodule

// File: rtl/bxc_chk.sv
// Protocol checker for bus_xlate_ctrl, attached by bind.
module bxc_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_ale,
    input logic [AW-1:0] bus_addr,
    input logic          bus_hbe_n,
    input logic          bus_memr_n,
    input logic          bus_memw_n,
    input logic          bus_ior_n,
    input logic          bus_iow_n,
    input logic          bus_doe,
    input logic          tgt_ready,
    input logic          busy,
    input logic          done
);
    logic cmd_any;
    assign cmd_any = ~(bus_memr_n & bus_memw_n & bus_ior_n & bus_iow_n);

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~bus_memr_n, ~bus_memw_n, ~bus_ior_n, ~bus_iow_n}) <= 1);

    // R2
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> !cmd_any);

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_any && !tgt_ready) |=> cmd_any);

    // R5
    wait_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_any && !tgt_ready) |=> $stable(bus_addr));

    // R7
    hbe_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && !bus_hbe_n) |-> !bus_addr[0]);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    doe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (bus_ale || !bus_memw_n || !bus_iow_n));

endmodule

bind bus_xlate_ctrl bxc_chk #(.AW(AW)) i_bxc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ale    (bus_ale),
    .bus_addr   (bus_addr),
    .bus_hbe_n  (bus_hbe_n),
    .bus_memr_n (bus_memr_n),
    .bus_memw_n (bus_memw_n),
    .bus_ior_n  (bus_ior_n),
    .bus_iow_n  (bus_iow_n),
    .bus_doe    (bus_doe),
    .tgt_ready  (tgt_ready),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_bus_xlate_ctrl.sv
module test_bus_xlate_ctrl;
    localparam int AW  = 24;
    localparam int C16 = 2;
    localparam int C8  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          busy, done;
    logic [15:0]   rd_data;
    logic          bus_ale, bus_hbe_n, bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_doe;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic          tgt_ready = 1'b1, tgt_nows_n = 1'b1, tgt_mem16_n = 1'b1, tgt_io16_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_xlate_ctrl #(.AW(AW), .CMD16_STATES(C16), .CMD8_STATES(C8)) i_bus_xlate_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .bus_ale(bus_ale), .bus_addr(bus_addr),
        .bus_hbe_n(bus_hbe_n), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
        .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .tgt_ready(tgt_ready), .tgt_nows_n(tgt_nows_n),
        .tgt_mem16_n(tgt_mem16_n), .tgt_io16_n(tgt_io16_n)
    );

    task automatic cmp(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected {memr,memw,ior,iow} in a command state (R3).
    function automatic logic [3:0] strobes(input bit wr, input bit io);
        logic [3:0] s = 4'hF;
        s[3 - (int'(io) * 2 + int'(wr))] = 1'b0;
        return s;
    endfunction

    // Behavioural model of one request; drives the target and compares
    // the bus every cycle. waits[s]: ready-low command states at the
    // start of sub-cycle s; nows_k: command index with no-wait-state low.
    task automatic run(input string ltag, input bit wr, input bit io, input bit wide,
                       input logic [AW-1:0] addr, input logic [15:0] wdata, input bit claim,
                       input int w0, input int w1, input int nows_k,
                       input logic [15:0] rdata, input bit poke);
        int nsub = (wide && !claim) ? 2 : 1;
        string dtag = wide ? (claim ? "R7" : "R8") : "R9";
        logic [15:0] exp_rd;
        if (wide && claim) exp_rd = rdata;
        else if (wide)     exp_rd = rdata;
        else               exp_rd = {8'h00, rdata[7:0]};

        @(negedge clk);
        cmp("R10", "busy before accept", busy, 1'b0);
        req_valid = 1'b1; req_write = wr; req_io = io; req_wide = wide;
        req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        for (int s = 0; s < nsub; s++) begin
            bit full = wide && claim;
            int lim = full ? C16 : C8;
            int waits = (s == 0) ? w0 : w1;
            logic [AW-1:0] ea = wide ? {addr[AW-1:1], s[0]} : addr;
            logic ehbe = !(wide && s == 0);
            logic [7:0] lane0 = (wide && s == 1) ? wdata[15:8] : wdata[7:0];
            bit fin = 0;
            int k = 0;
            // Status state.
            cmp("R2", "ale in status", bus_ale, 1'b1);
            cmp("R2", "no strobe in status", {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}, 4'hF);
            cmp(dtag, "status address", bus_addr, ea);
            cmp(dtag, "status hbe_n", bus_hbe_n, ehbe);
            cmp("R11", "doe in status", bus_doe, wr);
            cmp("R10", "busy in status", busy, 1'b1);
            @(negedge clk);
            while (!fin) begin
                tgt_ready  = (k >= waits);
                tgt_nows_n = !(k == nows_k);
                if (k == 0 && s == 0) begin
                    // R7: only the line matching the space counts.
                    tgt_mem16_n = io ? !(!claim) : !claim;
                    tgt_io16_n  = io ? !claim : !(!claim);
                    if (io) tgt_mem16_n = claim;
                    else    tgt_io16_n  = claim;
                end else begin
                    tgt_mem16_n = 1'b1; tgt_io16_n = 1'b1;
                end
                if (full)         bus_din = rdata;
                else if (s == 0)  bus_din = {8'hA5, rdata[7:0]};
                else              bus_din = {8'h5A, rdata[15:8]};
                if (poke && s == 0 && k == 0) begin
                    req_valid = 1'b1; req_addr = addr ^ 24'h000F00;
                end
                cmp("R2", "ale low in command", bus_ale, 1'b0);
                cmp(ltag, $sformatf("strobe sub%0d cmd%0d", s, k),
                    {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}, strobes(wr, io));
                cmp(dtag, "command address", bus_addr, ea);
                cmp(dtag, "command hbe_n", bus_hbe_n, ehbe);
                cmp("R11", "doe in command", bus_doe, wr);
                if (wr) begin
                    cmp(dtag, "write lane 0", bus_dout[7:0], lane0);
                    if (full) cmp("R7", "write lane 1", bus_dout[15:8], wdata[15:8]);
                end
                fin = tgt_ready && ((!io && k == nows_k) || (k + 1 >= lim));
                k++;
                @(negedge clk);
                if (poke) begin
                    req_valid = 1'b0; req_addr = addr;
                end
            end
            tgt_ready = 1'b1; tgt_nows_n = 1'b1;
            tgt_mem16_n = 1'b1; tgt_io16_n = 1'b1;
        end
        cmp("R10", "done pulse", done, 1'b1);
        cmp("R10", "busy at done", busy, 1'b0);
        cmp("R1", "idle strobes", {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_ale}, 5'h1E);
        cmp("R11", "doe idle", bus_doe, 1'b0);
        if (!wr) cmp(dtag, "read data", rd_data, exp_rd);
        @(negedge clk);
        cmp("R10", "done one cycle", done, 1'b0);
        cmp("R10", "no stray start", busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        cmp("R1", "ale", bus_ale, 1'b0);
        cmp("R1", "strobes", {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}, 4'hF);
        cmp("R1", "hbe_n", bus_hbe_n, 1'b1);
        cmp("R1", "doe", bus_doe, 1'b0);
        cmp("R1", "busy/done", {busy, done}, 2'b00);
        rst_n = 1'b1;

        run("R4", 0, 0, 1, 24'h012340, 16'h0000, 1, 0, 0, -1, 16'hBEEF, 0); // R7 mem read
        run("R4", 1, 0, 1, 24'h000102, 16'hCAFE, 1, 0, 0, -1, 16'h0000, 0); // R7 mem write
        run("R4", 1, 1, 1, 24'h000300, 16'h1234, 1, 0, 0, -1, 16'h0000, 0); // R7 io write
        run("R4", 0, 0, 1, 24'h0A0010, 16'h0000, 0, 0, 0, -1, 16'h9A7C, 0); // R8 split read
        run("R4", 1, 1, 1, 24'h000220, 16'h55AA, 0, 0, 0, -1, 16'h0000, 0); // R8 split io write
        run("R4", 0, 0, 0, 24'h00F003, 16'h0000, 0, 0, 0, -1, 16'h00C3, 0); // R9 byte read odd
        run("R4", 1, 1, 0, 24'h000061, 16'h7781, 0, 0, 0, -1, 16'h0000, 0); // R9 io byte write
        run("R5", 0, 0, 1, 24'h004000, 16'h0000, 1, 2, 0, -1, 16'h3C5A, 0); // R5 waits 16-bit
        run("R5", 0, 1, 1, 24'h000380, 16'h0000, 0, 1, 3, -1, 16'hE10F, 0); // R5 waits split
        run("R6", 0, 0, 0, 24'h000800, 16'h0000, 0, 0, 0, 1, 16'h0042, 0);  // R6 early end
        run("R6", 0, 1, 0, 24'h000081, 16'h0000, 0, 0, 0, 0, 16'h0017, 0);  // R6 ignored on I/O
        run("R6", 1, 0, 0, 24'h000900, 16'h00D4, 0, 2, 0, 1, 16'h0000, 0);  // R6 ready priority
        run("R6", 1, 0, 1, 24'h000904, 16'hA1B2, 1, 0, 0, 0, 16'h0000, 0);  // R6 one-state 16-bit
        run("R10", 1, 0, 1, 24'h000A00, 16'h6E6E, 1, 1, 0, -1, 16'h0000, 1); // R10 poke ignored

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule